// File: doc/BRIEF.md
# UART Receive Byte Queue

This block is the receive-side store of a register-mapped UART. A deserializer hands it one byte per strobe. A host pulls the bytes back out through a data register on a small read/write port. In queue mode the bytes go into a circular buffer. In pass-through mode each byte simply replaces a one-byte holding register. The block reports its occupancy, a full flag, a data-ready flag and a sticky error log. It also emits one-cycle receive and error event pulses, which feed a separate interrupt block.

A break indication from the line is treated as the arrival of a 0x00 byte and is also logged in the error register. Bit 1 of the control register clears the queue. That bit never reads back as set. Register reads are registered: the value and every side effect of a read belong to the cycle in which the read strobe is sampled.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the control register reads 0 (pass-through mode), the line, error and queue status registers read 0, the holding register reads 0, and no event pulse is produced.
- R2: With control bit 0 set (queue mode), bytes read from the data register (address 4) come back in arrival order. Each byte that is stored produces one rx_evt pulse on the cycle after its strobe.
- R3: The queue status register (address 3) holds the occupancy in bits 7:0 and the full flag in bit 8. When the queue holds DEPTH bytes it reads 0x0100, with the count field forced to zero.
- R4: A byte that arrives in queue mode while the queue is full and is not being read in the same cycle is dropped. The stored bytes are unchanged, no rx_evt is produced, err_evt pulses once, and the overrun bit (bit 0) of the error register (address 2) is set.
- R5: In queue mode, a data read while the queue is empty returns 0 and produces one err_evt pulse.
- R6: The data-ready bit (bit 0 of the line status register, address 1) is set in queue mode while the queue holds at least one byte. It clears when a read takes the last byte.
- R7: A break pulse stores 0x00 like a received byte (with its rx_evt) and sets the break bit (bit 3) of the error register. If a byte strobe arrives in the same cycle, the break wins.
- R8: Reading the error register returns its contents and clears it. A flag raised in the same cycle as that read survives into the next value.
- R9: Writing the control register (address 0) with bit 1 set empties the queue by the next cycle, even if a byte arrives in the same cycle, and that byte produces no rx_evt. Bit 1 always reads back as 0.
- R10: With control bit 0 clear, each arriving byte overwrites the holding register, sets data-ready and pulses rx_evt. A data read returns the latest byte, clears data-ready and never raises err_evt.
- R11: Reads of addresses 5 to 7 return 0. Writes to addresses 1 to 7 change no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe: byte_in carries a received byte |
| byte_in | input | 8 | Received byte from the deserializer |
| brk_pulse | input | 1 | One-cycle strobe: a line break was detected |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select (0 control, 1 line status, 2 error, 3 queue status, 4 data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| rx_evt | output | 1 | Pulse: a byte was accepted |
| err_evt | output | 1 | Pulse: a byte was dropped or an empty queue was read |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples its stimulus. Read data, both event pulses, the occupancy and the error log all come from a single register stage. The bench therefore drives each strobe for one cycle starting at a falling edge, and it samples reg_rdata at the next falling edge. Event pulses are tallied at falling edges, and the tallies are compared only after that falling edge has passed. The checks that depend on same-cycle collisions drive both strobes in one cycle so that they meet the same rising edge: clear against arrival, break against error-register read, and a full queue against a new byte.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int REG_W = 16;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_LINE  = 3'd1,
        A_ERR   = 3'd2,
        A_FSTAT = 3'd3,
        A_DATA  = 3'd4
    } rxq_addr_e;

    localparam int CTL_EN  = 0;
    localparam int CTL_CLR = 1;

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [7:0]       wbyte,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ring_t;

    ring_t st_d, st_q;
    logic [7:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push) st_d.wp = bump(st_q.wp);
            if (pop)  st_d.rp = bump(st_q.rp);
            st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem_q[st_q.wp] <= wbyte;
    end

    assign head = mem_q[st_q.rp];
    assign cnt  = st_q.cnt;

    // R3: occupancy never exceeds the depth
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R9: a clear empties the ring on the next edge
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && st_q.wp == st_q.rp));

endmodule

// File: rtl/rxq_errlog.sv
module rxq_errlog (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_ovr,
    input  logic       set_brk,
    input  logic       rd_clr,
    output logic [3:0] flags
);

    typedef struct packed {
        logic brk;
        logic ovr;
    } log_t;

    log_t lg_d, lg_q;

    always_comb begin
        lg_d = rd_clr ? '0 : lg_q;
        if (set_ovr) lg_d.ovr = 1'b1;
        if (set_brk) lg_d.brk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lg_q <= '0;
        else        lg_q <= lg_d;
    end

    // bit 0 overrun, bits 1 and 2 unused here, bit 3 break
    assign flags = {lg_q.brk, 2'b00, lg_q.ovr};

    // R8: a read with no new flag leaves the log empty
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !set_ovr && !set_brk) |=> (flags == 4'h0));

    // R7: a break always shows in the log on the next cycle
    a_r7_break_logged: assert property (@(posedge clk) disable iff (!rst_n)
        set_brk |=> flags[3]);

endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    input  logic             brk_pulse,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             rx_evt,
    output logic             err_evt
);

    typedef struct packed {
        logic [7:0]       ctl;
        logic             rdy;
        logic [7:0]       hold;
        logic [REG_W-1:0] rdata;
        logic             rx_evt;
        logic             err_evt;
    } top_t;

    top_t st_d, st_q;

    logic [7:0]       head;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       err_flags;

    logic             fifo_en, arrive, wr_ctl, clr, rd_data, rd_err;
    logic             full, empty, push, pop, drop;
    logic [7:0]       abyte, cnt8;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        fifo_en = st_q.ctl[CTL_EN];
        arrive  = byte_vld | brk_pulse;
        abyte   = brk_pulse ? 8'h00 : byte_in;
        wr_ctl  = reg_wr && (reg_addr == A_CTRL);
        clr     = wr_ctl && reg_wdata[CTL_CLR];
        rd_data = reg_rd && (reg_addr == A_DATA);
        rd_err  = reg_rd && (reg_addr == A_ERR);
        full    = (cnt == CNT_W'(DEPTH));
        empty   = (cnt == '0);
        cnt8    = 8'(cnt);
        pop     = rd_data && fifo_en && !empty && !clr;
        push    = arrive && fifo_en && !clr && (!full || pop);
        drop    = arrive && fifo_en && !clr && full && !pop;
        cnt_nx  = clr ? '0 : (cnt + CNT_W'(push) - CNT_W'(pop));

        st_d = st_q;
        st_d.rx_evt  = push || (arrive && !fifo_en);
        st_d.err_evt = drop || (rd_data && fifo_en && empty);

        if (wr_ctl) begin
            st_d.ctl = reg_wdata;
            st_d.ctl[CTL_CLR] = 1'b0;
        end

        if (!fifo_en && arrive) st_d.hold = abyte;

        if (fifo_en) begin
            st_d.rdy = (cnt_nx != '0);
        end else if (arrive) begin
            st_d.rdy = 1'b1;
        end else if (rd_data) begin
            st_d.rdy = 1'b0;
        end

        if (reg_rd) begin
            case (reg_addr)
                A_CTRL:  st_d.rdata = {8'h00, st_q.ctl};
                A_LINE:  st_d.rdata = {15'h0000, st_q.rdy};
                A_ERR:   st_d.rdata = {12'h000, err_flags};
                A_FSTAT: st_d.rdata = full ? 16'h0100 : {8'h00, cnt8};
                A_DATA: begin
                    if (fifo_en) st_d.rdata = empty ? 16'h0000 : {8'h00, head};
                    else         st_d.rdata = {8'h00, st_q.hold};
                end
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rxq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (push),
        .pop   (pop),
        .wbyte (abyte),
        .head  (head),
        .cnt   (cnt)
    );

    rxq_errlog u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ovr (drop),
        .set_brk (brk_pulse),
        .rd_clr  (rd_err),
        .flags   (err_flags)
    );

    assign reg_rdata = st_q.rdata;
    assign rx_evt    = st_q.rx_evt;
    assign err_evt   = st_q.err_evt;

    // R3: a full queue reports only the full flag
    a_r3_full_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_FSTAT && cnt == CNT_W'(DEPTH)) |=> (reg_rdata == 16'h0100));

    // R5: an empty read in queue mode yields zero and an error pulse
    a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_DATA && st_q.ctl[CTL_EN] && cnt == '0)
            |=> (err_evt && reg_rdata == '0));

    // R4: a byte hitting a full queue leaves the count unchanged
    a_r4_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && st_q.ctl[CTL_EN] && cnt == CNT_W'(DEPTH) && !reg_rd && !reg_wr)
            |=> (err_evt && !rx_evt && cnt == CNT_W'(DEPTH)));

    // R10: a pass-through read with no arrival drops data-ready
    a_r10_bypass_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_DATA && !st_q.ctl[CTL_EN] && !byte_vld && !brk_pulse)
            |=> (!st_q.rdy && !err_evt));

endmodule

// File: tb/rxq_buffer_test.sv
module rxq_buffer_test;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        brk_pulse = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rx_evt, err_evt;

    int n_chk = 0;
    int n_fail = 0;
    int rx_n = 0;
    int err_n = 0;

    always #2 clk = ~clk;

    rxq_buffer #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .brk_pulse(brk_pulse), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_evt(rx_evt), .err_evt(err_evt)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_evt)  rx_n++;
            if (err_evt) err_n++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1; byte_in = b;
        @(negedge clk);
        byte_vld = 1'b0;
        #1;
    endtask

    task automatic send_brk();
        @(negedge clk);
        brk_pulse = 1'b1;
        @(negedge clk);
        brk_pulse = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); check("R1 ctrl", v, 0);
        rd(3'd1, v); check("R1 line", v, 0);
        rd(3'd2, v); check("R1 err", v, 0);
        rd(3'd3, v); check("R1 fstat", v, 0);
        rd(3'd4, v); check("R1 hold", v, 0);
        check("R1 no events", rx_n + err_n, 0);
    endtask

    task automatic t_bypass();
        logic [15:0] v;
        int r0, e0;
        r0 = rx_n; e0 = err_n;
        send(8'h41);
        send(8'h42);
        rd(3'd1, v); check("R10 ready set", v, 1);
        rd(3'd4, v); check("R10 latest byte", v, 16'h42);
        rd(3'd1, v); check("R10 ready cleared", v, 0);
        rd(3'd4, v); check("R10 reread", v, 16'h42);
        check("R10 rx events", rx_n - r0, 2);
        check("R10 no error", err_n - e0, 0);
    endtask

    task automatic t_order();
        logic [15:0] v;
        int r0;
        wr(3'd0, 8'h01);
        r0 = rx_n;
        send(8'h11); send(8'h22); send(8'h33);
        check("R2 rx events", rx_n - r0, 3);
        rd(3'd3, v); check("R3 count", v, 3);
        rd(3'd1, v); check("R6 ready", v, 1);
        rd(3'd4, v); check("R2 first", v, 16'h11);
        rd(3'd4, v); check("R2 second", v, 16'h22);
        rd(3'd1, v); check("R6 ready kept", v, 1);
        rd(3'd4, v); check("R2 third", v, 16'h33);
        rd(3'd1, v); check("R6 ready cleared", v, 0);
    endtask

    task automatic t_empty();
        logic [15:0] v;
        int e0;
        e0 = err_n;
        rd(3'd4, v); check("R5 empty value", v, 0);
        check("R5 error pulse", err_n - e0, 1);
    endtask

    task automatic t_overflow();
        logic [15:0] v;
        int r0, e0;
        r0 = rx_n;
        for (int i = 0; i < DEPTH; i++) send(8'(i * 3 + 1));
        rd(3'd3, v); check("R3 full word", v, 16'h0100);
        e0 = err_n;
        send(8'hEE);
        check("R4 error pulse", err_n - e0, 1);
        check("R4 no rx for drop", rx_n - r0, DEPTH);
        rd(3'd2, v); check("R4 overrun bit", v, 1);
        rd(3'd2, v); check("R8 cleared", v, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(3'd4, v); check("R4 kept bytes", v, (i * 3 + 1) & 8'hFF);
        end
        rd(3'd3, v); check("R3 drained", v, 0);
    endtask

    task automatic t_break();
        logic [15:0] v;
        int r0;
        r0 = rx_n;
        send(8'h77);
        rd(3'd4, v); check("R2 before break", v, 16'h77);
        send_brk();
        check("R7 rx event", rx_n - r0, 2);
        rd(3'd3, v); check("R7 stored", v, 1);
        rd(3'd2, v); check("R7 break bit", v, 8);
        rd(3'd4, v); check("R7 null byte", v, 0);
    endtask

    task automatic t_clr_race();
        logic [15:0] v;
        rd(3'd2, v); check("R8 start clear", v, 0);
        @(negedge clk);
        reg_addr = 3'd2; reg_rd = 1'b1; brk_pulse = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; brk_pulse = 1'b0;
        #1;
        check("R8 read value", reg_rdata, 0);
        rd(3'd2, v); check("R8 new flag kept", v, 8);
        rd(3'd4, v); check("R7 null via race", v, 0);
    endtask

    task automatic t_fifo_reset();
        logic [15:0] v;
        int r0;
        send(8'hA1); send(8'hA2);
        r0 = rx_n;
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = 8'h03; reg_wr = 1'b1;
        byte_vld = 1'b1; byte_in = 8'h55;
        @(negedge clk);
        reg_wr = 1'b0; byte_vld = 1'b0;
        #1;
        check("R9 no rx for cleared byte", rx_n - r0, 0);
        rd(3'd3, v); check("R9 emptied", v, 0);
        rd(3'd0, v); check("R9 self clear", v, 1);
        rd(3'd1, v); check("R9 ready low", v, 0);
    endtask

    task automatic t_map();
        logic [15:0] v;
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hFF);
        wr(3'd1, 8'hFF);
        wr(3'd4, 8'h99);
        rd(3'd3, v); check("R11 fstat untouched", v, 0);
        rd(3'd2, v); check("R11 err untouched", v, 0);
        rd(3'd1, v); check("R11 line untouched", v, 0);
        rd(3'd6, v); check("R11 unmapped", v, 0);
        rd(3'd0, v); check("R11 ctrl", v, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_order();
        t_empty();
        t_overflow();
        t_break();
        t_clr_race();
        t_fifo_reset();
        t_map();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule